// File: doc/BRIEF.md
# Dual-Pipe Integer Issue Checker

Each cycle this block decides whether up to two decoded integer instructions can issue. The two execution pipes, E0 and E1, are not interchangeable, and every instruction class has a fixed set of pipes it may use. Slot 0 holds the older instruction and slot 1 the younger. Issue is in order, so slot 1 can never go ahead of a stalled slot 0.

The block also tracks a multiplier that is not pipelined. It holds that unit for a number of cycles that depends on the operand size, and it schedules when each result completes. Two cycles before a result completes, pipe E0 is closed to every instruction. A multiply whose operand comes from a recent integer producer is held back, because the multiplier cannot take data from the normal bypass paths.

The block models only occupancy and timing. It carries no operand data and performs no dependence scoreboarding.

Top module: `dual_pipe_issue`

## Requirements
- R1: A synchronous active-low reset clears all occupancy and completion state. After reset `mul_busy` and `mul_done` are 0, and a multiply in flight at reset never signals completion.
- R2: Class codes are 0 ALU (add/logic/compare/cmove), 1 LOAD, 2 LOCKLOAD, 3 STORE (store or barrier), 4 BRANCH (branch/jump-to-subroutine/privileged call), 5 SHIFT (shift/multimedia/misc), 6 MUL, 7 MULTI. Classes 2, 3, 5 and 6 use only E0, and class 4 uses only E1. A pipe output is 0 for E0 and 1 for E1.
- R3: Classes 0 and 1 may use either pipe. Slot 0 takes E0 unless E0 is closed or slot 1 holds an E0-only class; in those cases it takes E1. Slot 1 takes whichever pipe is free, preferring E0.
- R4: When both slots need the same single pipe, slot 0 is granted and slot 1 stalls. Slot 1 is never granted while slot 0 is valid and refused.
- R5: A store (class 3) never issues in the same cycle as a load (class 1 or 2). Two loads may issue together.
- R6: A MULTI instruction issues only with the other slot empty. It reports pipe 0 and occupies both pipes.
- R7: `mul_size` gives 0 = 32-bit, 1 = 64-bit low and 2 or 3 = 64-bit high. These hold the multiplier for 4, 8 and 8 cycles. `mul_busy` is 1 in the cycles after issue until the hold ends. While it is 1, a multiply is refused. A new multiply may issue in the first cycle after the hold.
- R8: `mul_done` pulses for exactly one cycle, 8, 12 or 14 cycles (by size) after the multiply's issue cycle. Overlapping multiplies each get their own pulse.
- R9: In the cycle exactly two before any multiply's completion, no instruction is granted on E0. Either-pipe classes move to E1 in that cycle.
- R10: A multiply flagged by `mul_dep` is refused until 3 cycles after the most recent granted producer (classes 0, 1, 2 or 5). This includes a producer granted in slot 0 in the same cycle. An unflagged multiply is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_class | input | 3 | Slot 0 class code (R2) |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_class | input | 3 | Slot 1 class code (R2) |
| mul_size | input | 2 | Operand size of the multiply in either slot |
| mul_dep | input | 1 | The multiply's operand comes from the latest producer |
| s0_grant | output | 1 | Slot 0 issues this cycle |
| s1_grant | output | 1 | Slot 1 issues this cycle |
| s0_pipe | output | 1 | Pipe of slot 0 when granted (0 = E0) |
| s1_pipe | output | 1 | Pipe of slot 1 when granted (0 = E0) |
| mul_busy | output | 1 | Multiplier held by an earlier multiply |
| mul_done | output | 1 | One-cycle pulse when a multiply result is ready |

## Verification
Grants and pipe choices are combinational, so they are checked in the same cycle the slot inputs are applied, shortly before the clock edge. `mul_busy` first shows in the cycle after a multiply issues. `mul_done` is due exactly 8, 12 or 14 cycles after the issue cycle, and the E0 closure comes two cycles earlier. The bench counts cycles from the issue window and checks the busy flag and the completion pulse in every window of the run. It therefore catches a pulse that comes early, comes late or lasts too long. Bypass holds are checked at one, two and three cycles after the producer.

// File: rtl/dual_issue_pkg.sv
// Shared types for the dual-pipe issue checker.
// Assumes a 3-bit class code whose values are fixed by the decoder.
package dual_issue_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_ALU      = 3'd0,
        CL_LOAD     = 3'd1,
        CL_LOCKLOAD = 3'd2,
        CL_STORE    = 3'd3,
        CL_BRANCH   = 3'd4,
        CL_SHIFT    = 3'd5,
        CL_MUL      = 3'd6,
        CL_MULTI    = 3'd7
    } iclass_e;

    typedef enum logic [1:0] {
        NEED_E0,
        NEED_E1,
        NEED_ANY,
        NEED_BOTH
    } pipe_need_e;

    function automatic pipe_need_e pipe_need(input iclass_e c);
        case (c)
            CL_ALU, CL_LOAD: return NEED_ANY;
            CL_BRANCH:       return NEED_E1;
            CL_MULTI:        return NEED_BOTH;
            default:         return NEED_E0;
        endcase
    endfunction

    function automatic logic is_load(input iclass_e c);
        return (c == CL_LOAD) || (c == CL_LOCKLOAD);
    endfunction

    function automatic logic is_producer(input iclass_e c);
        return (c == CL_ALU) || (c == CL_LOAD) || (c == CL_LOCKLOAD) || (c == CL_SHIFT);
    endfunction

endpackage

// File: rtl/bypass_timer.sv
// Counts the cycles since the latest granted integer producer.
// Assumes WAIT >= 2; pending_o is high until WAIT cycles have passed.
module bypass_timer #(
    parameter int WAIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prod_fire_i,
    output logic pending_o
);
    localparam int CW = $clog2(WAIT);

    logic [CW-1:0] cnt_q;

    // Reload on each producer grant, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (prod_fire_i)
            cnt_q <= CW'(WAIT - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pending_o = (cnt_q != '0);

    // R10
    prod_arms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_fire_i |=> pending_o);

endmodule

// File: rtl/mul_tracker.sv
// Holds the non-pipelined multiplier and schedules result completions.
// A one-hot-per-result shift register lets completions overlap.
// Assumes every latency is at least 3 and every hold is at least 2.
module mul_tracker #(
    parameter int LAT_32 = 8,
    parameter int LAT_LO = 12,
    parameter int LAT_HI = 14,
    parameter int OCC_32 = 4,
    parameter int OCC_LO = 8,
    parameter int OCC_HI = 8,
    parameter int E0_GAP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  logic [1:0] size_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       e0_blk_o
);
    localparam int MAXL_A = (LAT_LO > LAT_32) ? LAT_LO : LAT_32;
    localparam int MAXL   = (LAT_HI > MAXL_A) ? LAT_HI : MAXL_A;
    localparam int MAXO_A = (OCC_LO > OCC_32) ? OCC_LO : OCC_32;
    localparam int MAXO   = (OCC_HI > MAXO_A) ? OCC_HI : MAXO_A;
    localparam int OW     = $clog2(MAXO);

    logic [MAXL-1:0] sched_q;
    logic [OW-1:0]   occ_q;
    int              lat_sel;
    int              occ_sel;

    // Pick hold time and latency from the operand size.
    always_comb begin
        case (size_i)
            2'd0:    begin lat_sel = LAT_32; occ_sel = OCC_32; end
            2'd1:    begin lat_sel = LAT_LO; occ_sel = OCC_LO; end
            default: begin lat_sel = LAT_HI; occ_sel = OCC_HI; end
        endcase
    end

    // Advance the completion schedule and the hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= '0;
            occ_q   <= '0;
        end else begin
            sched_q <= (sched_q >> 1)
                     | (fire_i ? (MAXL'(1) << (lat_sel - 1)) : '0);
            if (fire_i)
                occ_q <= OW'(occ_sel - 1);
            else if (occ_q != '0)
                occ_q <= occ_q - 1'b1;
        end
    end

    assign busy_o   = (occ_q != '0);
    assign done_o   = sched_q[0];
    assign e0_blk_o = sched_q[E0_GAP];

    // R7
    hold_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> busy_o);
    // R7
    no_fire_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fire_i);
    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    results_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sched_q) <= 4);

endmodule

// File: rtl/issue_arbiter.sv
// Combinational per-cycle issue decision for two in-order slots.
// Assumes slot 0 is older; clk and rst_n serve only the assertions.
module issue_arbiter
    import dual_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld0_i,
    input  logic [CLS_W-1:0] cls0_i,
    input  logic             vld1_i,
    input  logic [CLS_W-1:0] cls1_i,
    input  logic             mul_dep_i,
    input  logic             mul_busy_i,
    input  logic             e0_blk_i,
    input  logic             dep_pend_i,
    output logic             gnt0_o,
    output logic             gnt1_o,
    output logic             pipe0_o,
    output logic             pipe1_o,
    output logic             mul_fire_o,
    output logic             prod_fire_o
);
    iclass_e    c0, c1;
    pipe_need_e n0, n1;
    logic       e0_used, e1_used, ldst_clash;

    assign c0 = iclass_e'(cls0_i);
    assign c1 = iclass_e'(cls1_i);
    assign n0 = pipe_need(c0);
    assign n1 = pipe_need(c1);

    // Decide slot 0 first, then slot 1 on the pipes that remain.
    always_comb begin
        gnt0_o = 1'b0;
        pipe0_o = 1'b0;
        if (vld0_i) begin
            case (n0)
                NEED_E1:  begin gnt0_o = 1'b1; pipe0_o = 1'b1; end
                NEED_ANY: begin
                    gnt0_o  = 1'b1;
                    pipe0_o = e0_blk_i || (vld1_i && (n1 == NEED_E0));
                end
                default:  gnt0_o = !e0_blk_i;
            endcase
            if (c0 == CL_MUL && (mul_busy_i || (mul_dep_i && dep_pend_i)))
                gnt0_o = 1'b0;
        end
        e0_used    = gnt0_o && !pipe0_o;
        e1_used    = gnt0_o && (pipe0_o || n0 == NEED_BOTH);
        ldst_clash = gnt0_o && ((c0 == CL_STORE && is_load(c1)) ||
                                (is_load(c0) && c1 == CL_STORE));

        gnt1_o = 1'b0;
        pipe1_o = 1'b0;
        if (vld1_i && (!vld0_i || gnt0_o)) begin
            case (n1)
                NEED_E0:  gnt1_o = !e0_blk_i && !e0_used;
                NEED_E1:  begin gnt1_o = !e1_used; pipe1_o = 1'b1; end
                NEED_ANY: begin
                    if (!e0_blk_i && !e0_used) begin
                        gnt1_o = 1'b1;
                    end else if (!e1_used) begin
                        gnt1_o  = 1'b1;
                        pipe1_o = 1'b1;
                    end
                end
                default:  gnt1_o = !vld0_i && !e0_blk_i;
            endcase
            if (ldst_clash)
                gnt1_o = 1'b0;
            if (c1 == CL_MUL && (mul_busy_i || (mul_dep_i &&
                    (dep_pend_i || (gnt0_o && is_producer(c0))))))
                gnt1_o = 1'b0;
        end
    end

    assign mul_fire_o  = (gnt0_o && c0 == CL_MUL) || (gnt1_o && c1 == CL_MUL);
    assign prod_fire_o = (gnt0_o && is_producer(c0)) || (gnt1_o && is_producer(c1));

    // R4
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt1_o |-> (!vld0_i || gnt0_o));
    // R5
    st_ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && gnt1_o) |-> !((c0 == CL_STORE && is_load(c1)) ||
                                 (c1 == CL_STORE && is_load(c0))));
    // R6
    multi_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && gnt1_o) |-> (c0 != CL_MULTI && c1 != CL_MULTI));
    // R9
    e0_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e0_blk_i |-> !((gnt0_o && !pipe0_o) || (gnt1_o && !pipe1_o)));
    // R10
    dep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_fire_o && mul_dep_i) |-> !dep_pend_i);

endmodule

// File: rtl/dual_pipe_issue.sv
// Top of the dual-pipe integer issue checker: arbiter, multiplier
// tracker and bypass timer. Assumes one multiply size per cycle.
module dual_pipe_issue
    import dual_issue_pkg::*;
#(
    parameter int LAT_32   = 8,
    parameter int LAT_LO   = 12,
    parameter int LAT_HI   = 14,
    parameter int OCC_32   = 4,
    parameter int OCC_LO   = 8,
    parameter int OCC_HI   = 8,
    parameter int E0_GAP   = 2,
    parameter int BYP_WAIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_valid,
    input  logic [CLS_W-1:0] s0_class,
    input  logic             s1_valid,
    input  logic [CLS_W-1:0] s1_class,
    input  logic [1:0]       mul_size,
    input  logic             mul_dep,
    output logic             s0_grant,
    output logic             s1_grant,
    output logic             s0_pipe,
    output logic             s1_pipe,
    output logic             mul_busy,
    output logic             mul_done
);
    logic e0_blk, dep_pend, mul_fire, prod_fire;

    issue_arbiter arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld0_i      (s0_valid),
        .cls0_i      (s0_class),
        .vld1_i      (s1_valid),
        .cls1_i      (s1_class),
        .mul_dep_i   (mul_dep),
        .mul_busy_i  (mul_busy),
        .e0_blk_i    (e0_blk),
        .dep_pend_i  (dep_pend),
        .gnt0_o      (s0_grant),
        .gnt1_o      (s1_grant),
        .pipe0_o     (s0_pipe),
        .pipe1_o     (s1_pipe),
        .mul_fire_o  (mul_fire),
        .prod_fire_o (prod_fire)
    );

    mul_tracker #(
        .LAT_32 (LAT_32), .LAT_LO (LAT_LO), .LAT_HI (LAT_HI),
        .OCC_32 (OCC_32), .OCC_LO (OCC_LO), .OCC_HI (OCC_HI),
        .E0_GAP (E0_GAP)
    ) mul_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (mul_fire),
        .size_i   (mul_size),
        .busy_o   (mul_busy),
        .done_o   (mul_done),
        .e0_blk_o (e0_blk)
    );

    bypass_timer #(.WAIT(BYP_WAIT)) byp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prod_fire_i (prod_fire),
        .pending_o   (dep_pend)
    );

endmodule

// File: tb/dual_pipe_issue_tb_top.sv
module dual_pipe_issue_tb_top;
    import dual_issue_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0_valid = 1'b0, s1_valid = 1'b0;
    logic [2:0] s0_class = 3'd0, s1_class = 3'd0;
    logic [1:0] mul_size = 2'd0;
    logic       mul_dep = 1'b0;
    logic       s0_grant, s1_grant, s0_pipe, s1_pipe, mul_busy, mul_done;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    dual_pipe_issue dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_class(s0_class),
        .s1_valid(s1_valid), .s1_class(s1_class),
        .mul_size(mul_size), .mul_dep(mul_dep),
        .s0_grant(s0_grant), .s1_grant(s1_grant),
        .s0_pipe(s0_pipe), .s1_pipe(s1_pipe),
        .mul_busy(mul_busy), .mul_done(mul_done)
    );

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            report();
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Set slot inputs at the falling edge, settle 1 ns before the rising edge.
    task automatic apply(input logic v0, input iclass_e c0, input logic v1,
                         input iclass_e c1, input logic [1:0] sz, input logic dep);
        s0_valid = v0; s0_class = c0; s1_valid = v1; s1_class = c1;
        mul_size = sz; mul_dep = dep;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        apply(1'b0, CL_ALU, 1'b0, CL_ALU, 2'd0, 1'b0);
    endtask

    // {req, v0, c0, v1, c1, g0, g1, p0, p1}
    localparam logic [15:0] VEC [16] = '{
        {4'd3, 1'b1, 3'd0, 1'b1, 3'd0, 4'b1101},  // R3 alu+alu
        {4'd3, 1'b1, 3'd4, 1'b1, 3'd0, 4'b1110},  // R3 branch+alu
        {4'd3, 1'b1, 3'd0, 1'b1, 3'd5, 4'b1110},  // R3 alu yields E0
        {4'd4, 1'b1, 3'd5, 1'b1, 3'd5, 4'b1000},  // R4 shift+shift
        {4'd4, 1'b1, 3'd4, 1'b1, 3'd4, 4'b1010},  // R4 branch+branch
        {4'd5, 1'b1, 3'd3, 1'b1, 3'd1, 4'b1000},  // R5 store+load
        {4'd5, 1'b1, 3'd1, 1'b1, 3'd3, 4'b1010},  // R5 load+store
        {4'd5, 1'b1, 3'd1, 1'b1, 3'd1, 4'b1101},  // R5 two loads
        {4'd2, 1'b1, 3'd2, 1'b1, 3'd1, 4'b1101},  // R2 lockload on E0
        {4'd6, 1'b1, 3'd7, 1'b1, 3'd0, 4'b1000},  // R6 multi first
        {4'd6, 1'b1, 3'd0, 1'b1, 3'd7, 4'b1000},  // R6 multi second
        {4'd6, 1'b0, 3'd0, 1'b1, 3'd7, 4'b0100},  // R6 multi alone
        {4'd2, 1'b0, 3'd0, 1'b1, 3'd4, 4'b0101},  // R2 branch on E1
        {4'd2, 1'b1, 3'd5, 1'b1, 3'd2, 4'b1000},  // R2 both E0-only
        {4'd2, 1'b1, 3'd4, 1'b1, 3'd3, 4'b1110},  // R2 store on E0
        {4'd4, 1'b0, 3'd0, 1'b0, 3'd0, 4'b0000}   // R4 nothing valid
    };

    // One multiply of a given size; probe busy, done and the E0 gap.
    task automatic run_mul(input logic [1:0] sz, input int occ, input int lat);
        apply(1'b1, CL_MUL, 1'b0, CL_ALU, sz, 1'b0);
        check("R7", "mul issue", s0_grant, 1);
        tick();
        for (int k = 1; k <= lat + 2; k++) begin
            if (k == occ - 1) begin
                apply(1'b1, CL_MUL, 1'b0, CL_ALU, sz, 1'b0);
                check("R7", "mul while held", s0_grant, 0);
            end else if (k == lat - 2) begin
                apply(1'b1, CL_SHIFT, 1'b0, CL_ALU, 2'd0, 1'b0);
                check("R9", "E0 closed", s0_grant, 0);
            end else if (k == lat - 1) begin
                apply(1'b1, CL_SHIFT, 1'b0, CL_ALU, 2'd0, 1'b0);
                check("R9", "E0 reopened", s0_grant, 1);
            end else begin
                idle();
            end
            check("R7", $sformatf("busy k=%0d", k), mul_busy, (k < occ) ? 1 : 0);
            check("R8", $sformatf("done k=%0d", k), mul_done, (k == lat) ? 1 : 0);
            tick();
        end
    endtask

    initial begin
        idle();
        tick(); tick();
        // R1: reset state
        check("R1", "busy after reset", mul_busy, 0);
        check("R1", "done after reset", mul_done, 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            automatic logic [15:0] v = VEC[i];
            automatic string r = $sformatf("R%0d", v[15:12]);
            apply(v[11], iclass_e'(v[10:8]), v[7], iclass_e'(v[6:4]), 2'd0, 1'b0);
            check(r, $sformatf("vec%0d g0", i), s0_grant, v[3]);
            check(r, $sformatf("vec%0d g1", i), s1_grant, v[2]);
            if (v[3]) check(r, $sformatf("vec%0d p0", i), s0_pipe, v[1]);
            if (v[2]) check(r, $sformatf("vec%0d p1", i), s1_pipe, v[0]);
            tick();
        end

        run_mul(2'd0, 4, 8);    // R7 R8 R9 32-bit
        run_mul(2'd1, 8, 12);   // 64-bit low
        run_mul(2'd3, 8, 14);   // code 3 acts as 64-bit high

        // R9: either-pipe class moves to E1 in the closed cycle
        apply(1'b1, CL_MUL, 1'b0, CL_ALU, 2'd0, 1'b0);
        tick();
        for (int k = 1; k <= 9; k++) begin
            if (k == 6) begin
                apply(1'b1, CL_ALU, 1'b0, CL_ALU, 2'd0, 1'b0);
                check("R9", "alu grant", s0_grant, 1);
                check("R9", "alu to E1", s0_pipe, 1);
            end else idle();
            tick();
        end

        // R7 R8: back-to-back overlap, 64-bit high then 32-bit at k=8
        apply(1'b1, CL_MUL, 1'b0, CL_ALU, 2'd2, 1'b0);
        tick();
        for (int k = 1; k <= 18; k++) begin
            if (k == 8) begin
                apply(1'b1, CL_MUL, 1'b0, CL_ALU, 2'd0, 1'b0);
                check("R7", "mul after hold", s0_grant, 1);
            end else idle();
            if (k == 7) check("R7", "busy last", mul_busy, 1);
            if (k == 8) check("R7", "busy ended", mul_busy, 0);
            check("R8", $sformatf("overlap done k=%0d", k), mul_done,
                  (k == 14 || k == 16) ? 1 : 0);
            tick();
        end

        // R10: dependent multiply waits for the bypass window
        apply(1'b1, CL_ALU, 1'b1, CL_MUL, 2'd0, 1'b1);
        check("R10", "same-cycle dep g0", s0_grant, 1);
        check("R10", "same-cycle dep g1", s1_grant, 0);
        tick();
        for (int k = 1; k <= 3; k++) begin
            apply(1'b1, CL_MUL, 1'b0, CL_ALU, 2'd0, 1'b1);
            check("R10", $sformatf("dep mul k=%0d", k), s0_grant, (k == 3) ? 1 : 0);
            tick();
        end
        for (int k = 0; k < 10; k++) begin idle(); tick(); end
        apply(1'b1, CL_ALU, 1'b1, CL_MUL, 2'd0, 1'b0);
        check("R10", "no-dep mul g1", s1_grant, 1);
        check("R10", "no-dep alu to E1", s0_pipe, 1);
        tick();
        for (int k = 0; k < 10; k++) begin idle(); tick(); end

        // R1: reset while a multiply is in flight
        apply(1'b1, CL_MUL, 1'b0, CL_ALU, 2'd0, 1'b0);
        tick();
        idle(); tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            idle();
            check("R1", "busy cleared", mul_busy, 0);
            check("R1", "no stale done", mul_done, 0);
            tick();
        end

        report();
        $finish;
    end

endmodule